// File: doc/BRIEF.md
# Reloading Countdown Timer

This block is a word-addressed timer peripheral that counts down from a programmed start value. A prescaler divides the system clock by 1, 16 or 256 to make count ticks, and the counter moves only while a run bit is set. When a tick finds the counter already at zero, an expiry event occurs. The counter is then refilled, either from the programmed start value or, with auto-reload off, from the largest count the block supports. A single register bus carries software writes and combinational reads at four word offsets.

Each expiry sets an interrupt status bit. In pulse mode the status lasts one cycle and clears itself, so every expiry gives a fresh interrupt. In latched mode the status stays set until software writes zero to the status offset, and later expiries do not raise it again while it is set. The interrupt pin is the status bit gated by an external enable input, which a system-level interrupt enable register drives.

Top module: `timer_reload_down`

## Requirements
- R1: After reset the start value, the counter, every control field, the status bit and the interrupt output are all zero.
- R2: A write to offset 0x00 stores bits 22:0 of the write data as the start value and copies them into the counter in the same cycle. It also restarts the prescaler phase. A read of offset 0x00 or offset 0x0C returns the start value with the upper bits zero.
- R3: While the run bit (control bit 7) is clear, the counter holds its value.
- R4: The prescaler field (control bits 3:2) selects the tick rate: 0 gives a tick every clock, 1 gives one every 16 clocks, and both 2 and 3 give one every 256 clocks. The first tick comes a full period after running starts.
- R5: Each tick decrements a nonzero counter by one. A tick that finds the counter at zero is an expiry, so one period lasts the start value plus one ticks.
- R6: With auto-reload (control bit 6) set, an expiry refills the counter from the start value.
- R7: With auto-reload clear, an expiry refills the counter with 0x7FFFFF.
- R8: With latch mode (control bit 0) clear, the status bit (control read bit 8) is set for exactly the one cycle that follows each expiry.
- R9: With latch mode set, the status bit stays set after an expiry, and counting continues. Only a write of zero to offset 0x0C clears it; a nonzero write there has no effect.
- R10: The interrupt output equals the status bit ANDed with the external enable input.
- R11: A read of offset 0x08 returns latch mode, prescaler, auto-reload and run in bits 0, 3:2, 6 and 7, the status in bit 8, and zero elsewhere. A read of offset 0x04 returns the counter, and writes to offset 0x04 are ignored.
- R12: A control write that changes the prescaler field restarts the prescaler phase, so the next tick comes one full new period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 4 | Byte offset; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_en | input | 1 | External interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that software changes the start value only through a write to offset 0x00, and that a write there in the same cycle as an expiry tick takes priority over the refill. The latched-status property also assumes the only clear comes from a zero write to the status offset. The stimulus issues bus writes one at a time, never aligned with an expiry tick. It stops the timer before clearing a latched status, so each assumption holds for every cycle the bench drives.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Word index taken from byte offset bits 3:2
  typedef enum logic [1:0] {
    IDX_START  = 2'd0,
    IDX_COUNT  = 2'd1,
    IDX_CTRL   = 2'd2,
    IDX_STATUS = 2'd3
  } tmr_idx_e;

  // Control field positions, fixed by the software view
  localparam int BIT_LATCH  = 0;
  localparam int BIT_PS_LO  = 2;
  localparam int BIT_PS_HI  = 3;
  localparam int BIT_AUTO   = 6;
  localparam int BIT_RUN    = 7;
  localparam int BIT_STAT   = 8;

  typedef struct packed {
    logic       run;
    logic       auto_rl;
    logic [1:0] psel;
    logic       latch;
  } tmr_ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_A_LOG = 4,
  parameter int DIV_B_LOG = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] psel,
  input  logic       restart,
  output logic       tick
);
  localparam int PW = DIV_B_LOG;
  localparam logic [PW-1:0] LIM_A = PW'((1 << DIV_A_LOG) - 1);
  localparam logic [PW-1:0] LIM_B = PW'((1 << DIV_B_LOG) - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] limit;

  always_comb begin
    case (psel)
      2'd0:    limit = '0;
      2'd1:    limit = LIM_A;
      default: limit = LIM_B;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run || restart) begin
      phase_q <= '0;
    end else if (phase_q == limit) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PW'(1);
    end
  end

  assign tick = run && !restart && (phase_q == limit);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             auto_rl,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_zero;
  assign at_zero = (cnt == '0);
  assign expire  = tick && at_zero && !ld_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ld_wr) begin
      cnt <= ld_val;
    end else if (tick) begin
      if (at_zero) begin
        cnt <= auto_rl ? start_val : CNT_MAX;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tmr_status.sv
module tmr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic latch,
  input  logic expire,
  input  logic clr_wr,
  input  logic irq_en,
  output logic status,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 1'b0;
    end else if (latch) begin
      status <= expire | (status & ~clr_wr);
    end else begin
      status <= expire;
    end
  end

  assign irq = status & irq_en;
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 23,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              status,
  output tmr_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  start_val,
  output logic [CNT_W-1:0]  ld_val,
  output logic              ld_wr,
  output logic              clr_wr,
  output logic              ps_restart
);
  tmr_idx_e idx;
  tmr_ctrl_t wr_ctrl;
  logic ctrl_wr;
  logic unused_bits;

  assign idx = tmr_idx_e'(bus_addr[3:2]);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  assign wr_ctrl.run     = bus_wdata[BIT_RUN];
  assign wr_ctrl.auto_rl = bus_wdata[BIT_AUTO];
  assign wr_ctrl.psel    = bus_wdata[BIT_PS_HI:BIT_PS_LO];
  assign wr_ctrl.latch   = bus_wdata[BIT_LATCH];

  assign ld_wr   = bus_wr && (idx == IDX_START);
  assign ctrl_wr = bus_wr && (idx == IDX_CTRL);
  assign clr_wr  = bus_wr && (idx == IDX_STATUS) && (bus_wdata == '0);
  assign ld_val  = bus_wdata[CNT_W-1:0];
  assign ps_restart = ld_wr || (ctrl_wr && (wr_ctrl.psel != ctrl.psel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      start_val <= '0;
    end else begin
      if (ld_wr)   start_val <= ld_val;
      if (ctrl_wr) ctrl      <= wr_ctrl;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_START, IDX_STATUS: bus_rdata = DATA_W'(start_val);
      IDX_COUNT:             bus_rdata = DATA_W'(cnt);
      default: begin
        bus_rdata[BIT_LATCH]           = ctrl.latch;
        bus_rdata[BIT_PS_HI:BIT_PS_LO] = ctrl.psel;
        bus_rdata[BIT_AUTO]            = ctrl.auto_rl;
        bus_rdata[BIT_RUN]             = ctrl.run;
        bus_rdata[BIT_STAT]            = status;
      end
    endcase
  end
endmodule

// File: rtl/timer_reload_down.sv
module timer_reload_down
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 23,
  parameter int DATA_W    = 32,
  parameter int DIV_A_LOG = 4,
  parameter int DIV_B_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_en,
  output logic              irq
);
  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] start_val;
  logic [CNT_W-1:0] ld_val;
  logic [CNT_W-1:0] cnt;
  logic             ld_wr;
  logic             clr_wr;
  logic             ps_restart;
  logic             tick;
  logic             expire;
  logic             status;

  tmr_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cnt        (cnt),
    .status     (status),
    .ctrl       (ctrl),
    .start_val  (start_val),
    .ld_val     (ld_val),
    .ld_wr      (ld_wr),
    .clr_wr     (clr_wr),
    .ps_restart (ps_restart)
  );

  tmr_prescale #(.DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .psel    (ctrl.psel),
    .restart (ps_restart),
    .tick    (tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .auto_rl   (ctrl.auto_rl),
    .ld_wr     (ld_wr),
    .ld_val    (ld_val),
    .start_val (start_val),
    .cnt       (cnt),
    .expire    (expire)
  );

  tmr_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .latch  (ctrl.latch),
    .expire (expire),
    .clr_wr (clr_wr),
    .irq_en (irq_en),
    .status (status),
    .irq    (irq)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             auto_rl,
  input logic             latch,
  input logic             tick,
  input logic             ld_wr,
  input logic             clr_wr,
  input logic             expire,
  input logic             status,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] start_val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_wr) |=> $stable(cnt));

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_wr && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R6
  refill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && auto_rl) |=> (cnt == $past(start_val)));

  // R7
  refill_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !auto_rl) |=> (cnt == CNT_MAX));

  // R8
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch && !expire) |=> !status);

  // R9
  latched_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && status && !clr_wr) |=> status);
endmodule

bind timer_reload_down tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (ctrl.run),
  .auto_rl   (ctrl.auto_rl),
  .latch     (ctrl.latch),
  .tick      (tick),
  .ld_wr     (ld_wr),
  .clr_wr    (clr_wr),
  .expire    (expire),
  .status    (status),
  .cnt       (cnt),
  .start_val (start_val)
);

// File: tb/test_timer_reload_down.sv
`timescale 1ns/1ps
module test_timer_reload_down;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_en = 1'b0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  timer_reload_down i_timer_reload_down (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); check("R1 start", v, 0);
    rd(4'h4, v); check("R1 count", v, 0);
    rd(4'h8, v); check("R1 ctrl", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(4'h0, 32'hFF00_0005);
    rd(4'h0, v); check("R2 start readback", v, 32'h5);
    rd(4'hC, v); check("R2 status offset readback", v, 32'h5);
    rd(4'h4, v); check("R2 count copied", v, 32'h5);
    wr(4'h4, 32'h9);
    rd(4'h4, v); check("R11 count write ignored", v, 32'h5);
    wr(4'h8, 32'hFFFF_FE4D);
    rd(4'h8, v); check("R11 ctrl readback", v, 32'h0000_004D);
    wr(4'h8, 32'h0);
    wait_n(10);
    rd(4'h4, v); check("R3 stopped holds", v, 32'h5);
  endtask

  task automatic t_div1_reload();
    logic [31:0] v;
    irq_en = 1'b1;
    wr(4'h0, 32'd3);
    wr(4'h8, 32'h0C0);
    for (int n = 1; n <= 3; n++) begin
      wait_n(1);
      rd(4'h4, v); check("R5 decrement", v, 32'(3 - n));
    end
    wait_n(1);
    rd(4'h4, v); check("R6 refill from start", v, 32'd3);
    rd(4'h8, v); check("R8 status after expiry", v[8], 1);
    check("R10 irq with enable", {31'b0, irq}, 1);
    wait_n(1);
    rd(4'h8, v); check("R8 status self clears", v[8], 0);
    rd(4'h4, v); check("R5 next period", v, 32'd2);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_noreload();
    logic [31:0] v;
    wr(4'h0, 32'd2);
    wr(4'h8, 32'h080);
    wait_n(3);
    rd(4'h4, v); check("R7 refill to max", v, 32'h7F_FFFF);
    wait_n(1);
    rd(4'h4, v); check("R7 counts from max", v, 32'h7F_FFFE);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    irq_en = 1'b0;
    wr(4'h0, 32'd1);
    wr(4'h8, 32'h0C1);
    wait_n(2);
    rd(4'h8, v); check("R9 latched set", v[8], 1);
    check("R10 irq gated off", {31'b0, irq}, 0);
    wait_n(1);
    rd(4'h4, v); check("R9 counting continues", v, 32'd0);
    wait_n(3);
    rd(4'h8, v); check("R9 latched stays", v[8], 1);
    irq_en = 1'b1;
    #1; check("R10 irq follows enable", {31'b0, irq}, 1);
    wr(4'h8, 32'h041);
    wr(4'hC, 32'h5);
    rd(4'h8, v); check("R9 nonzero write no clear", v[8], 1);
    wr(4'hC, 32'h0);
    rd(4'h8, v); check("R9 zero write clears", v[8], 0);
    check("R10 irq low after clear", {31'b0, irq}, 0);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_prescale(input logic [31:0] ctl, input int per, input string tag);
    logic [31:0] v;
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd10);
    wr(4'h8, ctl);
    wait_n(per - 1);
    rd(4'h4, v); check(tag, v, 32'd10);
    wait_n(1);
    rd(4'h4, v); check(tag, v, 32'd9);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd10);
    wr(4'h8, 32'h084);
    wait_n(8);
    wr(4'h8, 32'h088);
    wait_n(255);
    rd(4'h4, v); check("R12 psel change restarts phase", v, 32'd10);
    wait_n(1);
    rd(4'h4, v); check("R12 tick after new period", v, 32'd9);
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd10);
    wr(4'h8, 32'h084);
    wait_n(8);
    wr(4'h0, 32'd20);
    wait_n(15);
    rd(4'h4, v); check("R2 start write restarts phase", v, 32'd20);
    wait_n(1);
    rd(4'h4, v); check("R2 tick after full period", v, 32'd19);
    wr(4'h8, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_load();
    t_div1_reload();
    t_noreload();
    t_latch();
    t_prescale(32'h084, 16, "R4 divide by 16");
    t_prescale(32'h088, 256, "R4 divide by 256");
    t_prescale(32'h08C, 256, "R4 code 3 as 256");
    t_restart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule